// File: doc/BRIEF.md
# Watchdog Timer with Guarded Disable

This block is a watchdog counter clocked by its own dedicated watchdog clock, separate from the system clock that software uses to reach it. Software proves it is alive by writing a refresh register at regular intervals. If no refresh reaches the counter before the selected timeout expires, the block raises a system reset pulse of fixed length. The system is held in a defined state and does not respond while that pulse is high. After the pulse, the counter starts again from zero.

Software reaches the block through a small write port on the system clock: a refresh register, a key register and a control register. The control register holds an enable bit and a timeout select. Enabling is always allowed. Disabling the watchdog, or changing its timeout select, is accepted only in a short window opened by writing the correct key value. Any other attempt is discarded, so a stray or corrupted write cannot switch the watchdog off. Refreshes and configuration changes reach the watchdog clock domain through toggle synchronizers.

Top module: `guarded_watchdog`

## Requirements
- R1: After reset `wd_rst_o` is low, the watchdog is enabled with timeout select 3, and with no refresh the first reset pulse rises about 128 watchdog cycles after reset is released.
- R2: A write to address 0 (any data) restarts the count from zero; refreshes every 50 watchdog cycles at select 3 keep `wd_rst_o` low, and once they stop a pulse follows.
- R3: With the watchdog enabled and no refresh, `wd_rst_o` stays low for exactly 2^(4+select) watchdog cycles between the end of one pulse and the start of the next.
- R4: Each reset pulse holds `wd_rst_o` high for exactly 8 watchdog cycles, after which the counter restarts from zero.
- R5: A refresh written while the pulse is high neither shortens nor lengthens the pulse.
- R6: Writing 8'h5C to address 1 opens a window; a write to address 2 in any of the next four system clock cycles loads bit 7 as the enable and bits 2:0 as the timeout select, and closes the window.
- R7: A write to address 2 with bit 7 = 0 while no window is open is ignored, and the watchdog stays enabled.
- R8: While no window is open, bits 2:0 of a write to address 2 are ignored, and the timeout select keeps its value.
- R9: A control write five or more system cycles after the key write is treated as unguarded; a write of any other value to address 1 closes an open window.
- R10: A write to address 2 with bit 7 = 1 enables the watchdog without any key write.
- R11: While the watchdog is disabled no reset pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | System clock for the register write port |
| rst_sys_n | input | 1 | Active-low asynchronous reset, system clock domain |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 refresh, 1 key, 2 control |
| wr_data | input | 8 | Write data |
| clk_wd | input | 1 | Dedicated watchdog clock |
| rst_wd_n | input | 1 | Active-low asynchronous reset, watchdog clock domain |
| wd_rst_o | output | 1 | System reset pulse, watchdog clock domain |

## Verification
A refresh can reach the counter in a cycle where the reset pulse is already high. A refresh can also arrive in the same cycle that the timeout would fire. The bench provokes the first case by writing a refresh as soon as the pulse is seen high, and then checks that the pulse still lasts exactly 8 watchdog cycles. The window logic meets a similar collision when a control write lands on the last cycle of the window or one cycle after it. A table of key values, gaps and interleaved bad keys checks each case by whether reset pulses still appear.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;
    localparam int SEL_W = 3;
    localparam int DW    = 8;

    typedef enum logic [1:0] {
        A_KICK = 2'd0,
        A_KEY  = 2'd1,
        A_CTRL = 2'd2
    } wd_addr_e;

    typedef struct packed {
        logic             en;
        logic [SEL_W-1:0] sel;
    } wd_cfg_t;
endpackage

// File: rtl/wdt_sync.sv
`timescale 1ns/1ps
module wdt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            sh_d[i] = sh_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/wdt_ctrl.sv
`timescale 1ns/1ps
module wdt_ctrl
    import wdt_pkg::*;
#(
    parameter int           WIN_CYC = 4,
    parameter int           DEF_SEL = 3,
    parameter logic [DW-1:0] KEY    = 8'h5C
) (
    input  logic          clk_sys,
    input  logic          rst_sys_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic          ref_tgl_o,
    output logic          cfg_tgl_o,
    output wd_cfg_t       cfg_o
);
    localparam int              WW    = $clog2(WIN_CYC + 1);
    localparam logic [WW-1:0]   WIN_V = WW'(WIN_CYC);
    localparam int              EN_BIT = DW - 1;

    typedef struct packed {
        logic [WW-1:0] win;
        wd_cfg_t       cfg;
        logic          cfg_tgl;
        logic          ref_tgl;
    } ctl_st_t;

    ctl_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.win != '0) s_d.win = s_q.win - WW'(1);
        if (wr_en) begin
            case (wr_addr)
                A_KICK: s_d.ref_tgl = ~s_q.ref_tgl;
                A_KEY:  s_d.win = (wr_data == KEY) ? WIN_V : '0;
                A_CTRL: begin
                    if (s_q.win != '0) begin
                        s_d.cfg.en  = wr_data[EN_BIT];
                        s_d.cfg.sel = wr_data[SEL_W-1:0];
                    end else if (wr_data[EN_BIT]) begin
                        s_d.cfg.en = 1'b1;
                    end
                    s_d.win = '0;
                end
                default: ;
            endcase
        end
        if (s_d.cfg != s_q.cfg) s_d.cfg_tgl = ~s_q.cfg_tgl;
    end

    always_ff @(posedge clk_sys or negedge rst_sys_n) begin
        if (!rst_sys_n) begin
            s_q.win     <= '0;
            s_q.cfg.en  <= 1'b1;
            s_q.cfg.sel <= SEL_W'(DEF_SEL);
            s_q.cfg_tgl <= 1'b0;
            s_q.ref_tgl <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ref_tgl_o = s_q.ref_tgl;
    assign cfg_tgl_o = s_q.cfg_tgl;
    assign cfg_o     = s_q.cfg;

    // R6: a correct key opens a full-length window
    p_key_arms_r6: assert property (@(posedge clk_sys) disable iff (!rst_sys_n)
        (wr_en && wr_addr == A_KEY && wr_data == KEY) |=> (s_q.win == WIN_V));
    // R7: no unguarded disable
    p_no_disable_r7: assert property (@(posedge clk_sys) disable iff (!rst_sys_n)
        (wr_en && wr_addr == A_CTRL && s_q.win == '0) |=> (s_q.cfg.en || !$past(s_q.cfg.en)));
    // R8: no unguarded select change
    p_sel_locked_r8: assert property (@(posedge clk_sys) disable iff (!rst_sys_n)
        (wr_en && wr_addr == A_CTRL && s_q.win == '0) |=> (s_q.cfg.sel == $past(s_q.cfg.sel)));
    // R2: each refresh write flips the crossing toggle
    p_kick_toggles_r2: assert property (@(posedge clk_sys) disable iff (!rst_sys_n)
        (wr_en && wr_addr == A_KICK) |=> (s_q.ref_tgl != $past(s_q.ref_tgl)));
    // R6: a configuration change is always announced across the crossing
    p_cfg_flagged_r6: assert property (@(posedge clk_sys) disable iff (!rst_sys_n)
        (s_q.cfg != $past(s_q.cfg)) |-> (s_q.cfg_tgl != $past(s_q.cfg_tgl)));
endmodule

// File: rtl/wdt_core.sv
`timescale 1ns/1ps
module wdt_core
    import wdt_pkg::*;
#(
    parameter int MIN_LOG   = 4,
    parameter int PULSE_CYC = 8,
    parameter int DEF_SEL   = 3
) (
    input  logic    clk_wd,
    input  logic    rst_wd_n,
    input  logic    ref_tgl_s,
    input  logic    cfg_tgl_s,
    input  wd_cfg_t cfg_in,
    output logic    rst_act
);
    localparam int            CNT_W = MIN_LOG + (1 << SEL_W) - 1;
    localparam int            HW    = $clog2(PULSE_CYC + 1);
    localparam logic [HW-1:0] PULSE_V = HW'(PULSE_CYC);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [HW-1:0]    hold;
        logic             en;
        logic [SEL_W-1:0] sel;
        logic             ref_prev;
        logic             cfg_prev;
    } core_st_t;

    core_st_t         s_d, s_q;
    logic [CNT_W-1:0] lim_m1;
    logic             kick, cfg_new;

    always_comb begin
        lim_m1  = CNT_W'((32'd1 << (MIN_LOG + 32'(s_q.sel))) - 32'd1);
        kick    = ref_tgl_s ^ s_q.ref_prev;
        cfg_new = cfg_tgl_s ^ s_q.cfg_prev;

        s_d          = s_q;
        s_d.ref_prev = ref_tgl_s;
        s_d.cfg_prev = cfg_tgl_s;
        if (cfg_new) begin
            s_d.en  = cfg_in.en;
            s_d.sel = cfg_in.sel;
        end
        if (s_q.hold != '0) begin
            s_d.hold = s_q.hold - HW'(1);
            s_d.cnt  = '0;
        end else if (!s_q.en || kick || cfg_new) begin
            s_d.cnt = '0;
        end else if (s_q.cnt == lim_m1) begin
            s_d.hold = PULSE_V;
            s_d.cnt  = '0;
        end else begin
            s_d.cnt = s_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk_wd or negedge rst_wd_n) begin
        if (!rst_wd_n) begin
            s_q.cnt      <= '0;
            s_q.hold     <= '0;
            s_q.en       <= 1'b1;
            s_q.sel      <= SEL_W'(DEF_SEL);
            s_q.ref_prev <= 1'b0;
            s_q.cfg_prev <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rst_act = (s_q.hold != '0);

    // checker state: length of the current pulse
    logic [HW:0] run_q;
    always_ff @(posedge clk_wd or negedge rst_wd_n) begin
        if (!rst_wd_n)    run_q <= '0;
        else if (rst_act) run_q <= run_q + (HW+1)'(1);
        else              run_q <= '0;
    end

    // R3: a pulse starts only when the count has reached its limit
    p_fire_at_limit_r3: assert property (@(posedge clk_wd) disable iff (!rst_wd_n)
        $rose(rst_act) |-> ($past(s_q.cnt) == $past(lim_m1) && $past(s_q.en)));
    // R4: every pulse lasts PULSE_CYC cycles
    p_pulse_len_r4: assert property (@(posedge clk_wd) disable iff (!rst_wd_n)
        $fell(rst_act) |-> (run_q == (HW+1)'(PULSE_CYC)));
    // R5: the count stays cleared during the pulse
    p_idle_in_pulse_r5: assert property (@(posedge clk_wd) disable iff (!rst_wd_n)
        rst_act |-> (s_q.cnt == '0));
    // R11: a disabled watchdog never starts a pulse
    p_quiet_off_r11: assert property (@(posedge clk_wd) disable iff (!rst_wd_n)
        (!s_q.en && !rst_act) |=> !rst_act);
    // R3: the count never passes the selected limit
    p_cnt_range_r3: assert property (@(posedge clk_wd) disable iff (!rst_wd_n)
        s_q.cnt <= lim_m1);
endmodule

// File: rtl/guarded_watchdog.sv
`timescale 1ns/1ps
module guarded_watchdog
    import wdt_pkg::*;
#(
    parameter int            MIN_LOG     = 4,
    parameter int            DEF_SEL     = 3,
    parameter int            PULSE_CYC   = 8,
    parameter int            WIN_CYC     = 4,
    parameter int            SYNC_STAGES = 2,
    parameter logic [DW-1:0] KEY         = 8'h5C
) (
    input  logic          clk_sys,
    input  logic          rst_sys_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          clk_wd,
    input  logic          rst_wd_n,
    output logic          wd_rst_o
);
    localparam int NCH = 2;

    logic [NCH-1:0] tgl_src, tgl_dst;
    wd_cfg_t        cfg;

    wdt_ctrl #(
        .WIN_CYC (WIN_CYC),
        .DEF_SEL (DEF_SEL),
        .KEY     (KEY)
    ) u_ctrl (
        .clk_sys   (clk_sys),
        .rst_sys_n (rst_sys_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .ref_tgl_o (tgl_src[0]),
        .cfg_tgl_o (tgl_src[1]),
        .cfg_o     (cfg)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_xing
        wdt_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk_wd),
            .rst_n (rst_wd_n),
            .d     (tgl_src[g]),
            .q     (tgl_dst[g])
        );
    end

    wdt_core #(
        .MIN_LOG   (MIN_LOG),
        .PULSE_CYC (PULSE_CYC),
        .DEF_SEL   (DEF_SEL)
    ) u_core (
        .clk_wd    (clk_wd),
        .rst_wd_n  (rst_wd_n),
        .ref_tgl_s (tgl_dst[0]),
        .cfg_tgl_s (tgl_dst[1]),
        .cfg_in    (cfg),
        .rst_act   (wd_rst_o)
    );
endmodule

// File: tb/test_guarded_watchdog.sv
`timescale 1ns/1ps
module test_guarded_watchdog;
    logic       clk_sys = 1'b0, clk_wd = 1'b0;
    logic       rst_sys_n = 1'b0, rst_wd_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       wd_rst_o;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    localparam int PULSE = 8;
    localparam int LIM3  = 1 << (4 + 3);

    // {key, gap, bad key in between, expect disabled}
    localparam logic [13:0] VEC [7] = '{
        {8'h5C, 4'd1, 1'b0, 1'b1},
        {8'h5C, 4'd2, 1'b0, 1'b1},
        {8'h5C, 4'd4, 1'b0, 1'b1},
        {8'h5C, 4'd5, 1'b0, 1'b0},
        {8'h5C, 4'd6, 1'b0, 1'b0},
        {8'hA3, 4'd1, 1'b0, 1'b0},
        {8'h5C, 4'd2, 1'b1, 1'b0}
    };

    always #2.5  clk_sys = ~clk_sys;
    always #11.5 clk_wd  = ~clk_wd;

    guarded_watchdog i_guarded_watchdog (
        .clk_sys   (clk_sys),
        .rst_sys_n (rst_sys_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .clk_wd    (clk_wd),
        .rst_wd_n  (rst_wd_n),
        .wd_rst_o  (wd_rst_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_sys_n = 1'b0;
        rst_wd_n  = 1'b0;
        wr_en     = 1'b0;
        repeat (4) @(negedge clk_wd);
        rst_sys_n = 1'b1;
        rst_wd_n  = 1'b1;
    endtask

    task automatic sync_sys();
        @(negedge clk_sys);
    endtask

    // call at a clk_sys falling edge; write is taken at the next rising edge
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk_sys);
        wr_en = 1'b0;
    endtask

    task automatic wait_high(output int n);
        n = 0;
        forever begin
            @(negedge clk_wd);
            if (wd_rst_o) break;
            n++;
            if (n > 5000) break;
        end
    endtask

    task automatic measure_high(input bit kick, output int n);
        n = 1;
        if (kick) begin
            sync_sys();
            wr(2'd0, 8'h00);
        end
        forever begin
            @(negedge clk_wd);
            if (!wd_rst_o) break;
            n++;
            if (n > 100) break;
        end
    endtask

    task automatic count_pulses(input int cyc, output int p);
        logic prev;
        p = 0;
        prev = wd_rst_o;
        repeat (cyc) begin
            @(negedge clk_wd);
            if (wd_rst_o && !prev) p++;
            prev = wd_rst_o;
        end
    endtask

    initial begin
        #900000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int n, len, p, tot;

        // R1: reset state and first timeout
        do_reset();
        @(negedge clk_wd);
        check(wd_rst_o == 1'b0, "R1 output low after reset", int'(wd_rst_o), 0);
        wait_high(n);
        check(n >= LIM3 - 3 && n <= LIM3 + 1, "R1 first pulse delay", n + 1, LIM3);
        // R4: pulse length and restart from zero
        measure_high(1'b0, len);
        check(len == PULSE, "R4 pulse length", len, PULSE);
        wait_high(n);
        check(n + 1 == LIM3, "R4 restart from zero", n + 1, LIM3);
        // R5: refresh while the pulse is high
        measure_high(1'b1, len);
        check(len == PULSE, "R5 pulse with refresh", len, PULSE);

        // R2: regular refresh keeps the output low
        do_reset();
        tot = 0;
        for (int k = 0; k < 30; k++) begin
            sync_sys();
            wr(2'd0, 8'h3C);
            count_pulses(50, p);
            tot += p;
        end
        check(tot == 0, "R2 refreshed no pulse", tot, 0);
        count_pulses(200, p);
        check(p >= 1, "R2 pulse after refresh stops", p, 1);

        // R3, R6: guarded select change, timeout per select
        for (int s = 0; s < 3; s++) begin
            do_reset();
            sync_sys();
            wr(2'd1, 8'h5C);
            wr(2'd2, 8'h80 | 8'(s));
            wait_high(n);
            measure_high(1'b0, len);
            wait_high(n);
            check(n + 1 == (1 << (4 + s)), "R3 R6 timeout for select", n + 1, 1 << (4 + s));
        end

        // R8: unguarded select change ignored
        do_reset();
        sync_sys();
        wr(2'd2, 8'h80);
        wait_high(n);
        measure_high(1'b0, len);
        wait_high(n);
        check(n + 1 == LIM3, "R8 select kept", n + 1, LIM3);

        // R7: unguarded disable ignored
        do_reset();
        sync_sys();
        wr(2'd2, 8'h00);
        count_pulses(400, p);
        check(p >= 1, "R7 still enabled", p, 1);

        // R11, R10: guarded disable, then unguarded enable
        do_reset();
        sync_sys();
        wr(2'd1, 8'h5C);
        wr(2'd2, 8'h03);
        count_pulses(600, p);
        check(p == 0, "R11 no pulse while disabled", p, 0);
        sync_sys();
        wr(2'd2, 8'h80);
        wait_high(n);
        check(n <= LIM3 + 6, "R10 enable without key", n, LIM3);
        measure_high(1'b0, len);
        wait_high(n);
        check(n + 1 == LIM3, "R10 R8 select unchanged on enable", n + 1, LIM3);

        // R6, R9: window table
        for (int v = 0; v < 7; v++) begin
            logic [7:0] key;
            int         gap;
            bit         mid, off;
            key = VEC[v][13:6];
            gap = int'(VEC[v][5:2]);
            mid = VEC[v][1];
            off = VEC[v][0];
            do_reset();
            repeat (3) sync_sys();
            wr(2'd1, key);
            if (mid) begin
                wr(2'd1, 8'hFF);
                repeat (gap - 2) @(negedge clk_sys);
            end else begin
                repeat (gap - 1) @(negedge clk_sys);
            end
            wr(2'd2, 8'h03);
            count_pulses(400, p);
            if (off) check(p == 0, "R6 disable inside window", p, 0);
            else     check(p >= 1, "R9 disable rejected", p, 1);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule